// File: doc/BRIEF.md
# Conditional Branch Resolver

This block decides, once per cycle, where a single-cycle 32-bit processor fetches next. It takes the result of the ALU comparison (a subtraction of the two source registers) and the zero flag. It also takes a branch enable from the control decoder, a two-bit condition code, the already-incremented program counter and the sign-extended 16-bit immediate. From these it selects either the sequential address or a PC-relative target.

Four conditions are supported: equal, not equal, below zero and at-or-above zero. The control decoder is expected to feed register zero as the second operand for the two sign tests, so the ALU result is simply the first operand. The sign is read from the top bit of the ALU result. The chosen address is held in a program-counter register with a synchronous reset to zero.

Top module: `branch_resolver`

## Requirements
- R1: With `br_en` high and `br_cond` = 2'b00 (equal), `br_taken` is 1 exactly when `zero_flag` is 1.
- R2: With `br_en` high and `br_cond` = 2'b01 (not equal), `br_taken` is 1 exactly when `zero_flag` is 0.
- R3: With `br_en` high and `br_cond` = 2'b10 (below zero), `br_taken` is 1 exactly when bit 31 of `alu_result` is 1.
- R4: With `br_en` high and `br_cond` = 2'b11 (at or above zero), `br_taken` is 1 exactly when bit 31 of `alu_result` is 0.
- R5: With `br_en` low, `br_taken` is 0 whatever the flags, the ALU result and the condition code are, and the PC advances to `pc_plus4`.
- R6: `br_target` equals `pc_plus4` plus `imm_ext` shifted left by two, modulo 2^32. An immediate of -8 gives a target 32 bytes below `pc_plus4`.
- R7: On each rising clock edge out of reset, `pc_q` loads `br_target` if `br_taken` was 1 before the edge, and `pc_plus4` otherwise.
- R8: A rising edge with `rst` high sets `pc_q` to 0, even when a branch is being taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| br_en | input | 1 | Branch instruction in flight |
| br_cond | input | 2 | Condition: 00 equal, 01 not equal, 10 below zero, 11 at or above zero |
| alu_result | input | 32 | Result of the ALU subtraction |
| zero_flag | input | 1 | ALU result is zero |
| pc_plus4 | input | 32 | Sequential fetch address |
| imm_ext | input | 32 | Sign-extended word offset |
| br_taken | output | 1 | Branch condition holds |
| br_target | output | 32 | PC-relative branch destination |
| pc_q | output | 32 | Registered next fetch address |

## Verification
The bench builds the resolver at its default 32-bit width. A subtract stub in the bench produces the ALU result and the zero flag. The bench sweeps every condition code with the enable both high and low. It uses operand pairs that are equal, that differ in either order, that are zero, and that sit at the most negative and most positive values, so that the sign bit of the difference is seen in both states. Offsets of zero, one, -8 and both 16-bit extremes show forward and backward targets and wrap at the address boundary. A reset applied while a branch is taken shows that reset has priority.

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_en,
  input  logic [1:0]        br_cond,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              zero_flag,
  input  logic [DATA_W-1:0] pc_plus4,
  input  logic [DATA_W-1:0] imm_ext,
  output logic              br_taken,
  output logic [DATA_W-1:0] br_target,
  output logic [DATA_W-1:0] pc_q
);
  localparam int WORD_SHIFT = 2;

  logic negative;
  logic cond_met;

  assign negative = alu_result[DATA_W-1];

  always_comb begin
    unique case (br_cond)
      2'b00:   cond_met = zero_flag;
      2'b01:   cond_met = ~zero_flag;
      2'b10:   cond_met = negative;
      default: cond_met = ~negative;
    endcase
  end

  assign br_taken  = br_en & cond_met;
  assign br_target = pc_plus4 + (imm_ext << WORD_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= br_taken ? br_target : pc_plus4;
  end
endmodule

module branch_resolver_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              br_en,
  input logic [1:0]        br_cond,
  input logic [DATA_W-1:0] alu_result,
  input logic              zero_flag,
  input logic [DATA_W-1:0] pc_plus4,
  input logic              br_taken,
  input logic [DATA_W-1:0] br_target,
  input logic [DATA_W-1:0] pc_q
);
  assert_eq_R1: assert property (@(posedge clk) disable iff (rst)
    (br_en && br_cond == 2'b00) |-> (br_taken == zero_flag));
  assert_ne_R2: assert property (@(posedge clk) disable iff (rst)
    (br_en && br_cond == 2'b01) |-> (br_taken == !zero_flag));
  assert_ltz_R3: assert property (@(posedge clk) disable iff (rst)
    (br_en && br_cond == 2'b10) |-> (br_taken == alu_result[DATA_W-1]));
  assert_gez_R4: assert property (@(posedge clk) disable iff (rst)
    (br_en && br_cond == 2'b11) |-> (br_taken == !alu_result[DATA_W-1]));
  assert_no_enable_R5: assert property (@(posedge clk) disable iff (rst)
    !br_en |-> !br_taken);
  assert_pc_load_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pc_q == ($past(br_taken) ? $past(br_target) : $past(pc_plus4))));
endmodule

bind branch_resolver branch_resolver_checker #(.DATA_W(DATA_W)) u_checker (
  .clk(clk), .rst(rst), .br_en(br_en), .br_cond(br_cond),
  .alu_result(alu_result), .zero_flag(zero_flag), .pc_plus4(pc_plus4),
  .br_taken(br_taken), .br_target(br_target), .pc_q(pc_q)
);

// File: tb/branch_resolver_test.sv
`timescale 1ns/1ps
module branch_resolver_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        br_en;
  logic [1:0]  br_cond;
  logic [31:0] alu_result;
  logic        zero_flag;
  logic [31:0] pc_plus4;
  logic [31:0] imm_ext;
  logic        br_taken;
  logic [31:0] br_target;
  logic [31:0] pc_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  branch_resolver uut (
    .clk(clk), .rst(rst), .br_en(br_en), .br_cond(br_cond),
    .alu_result(alu_result), .zero_flag(zero_flag), .pc_plus4(pc_plus4),
    .imm_ext(imm_ext), .br_taken(br_taken), .br_target(br_target), .pc_q(pc_q)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string cond_req(input logic [1:0] c, input logic en);
    if (!en) return "R5";
    case (c)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic step(input logic [31:0] a, input logic [31:0] b, input logic [1:0] c,
                      input logic en, input logic [31:0] pc4, input logic [31:0] imm);
    logic [31:0] diff;
    logic        exp_take;
    logic [31:0] exp_tgt;
    logic [31:0] exp_pc;
    diff = a - b;
    case (c)
      2'b00: exp_take = (a == b);
      2'b01: exp_take = (a != b);
      2'b10: exp_take = ($signed(diff) < 0);
      default: exp_take = ($signed(diff) >= 0);
    endcase
    exp_take = exp_take & en;
    exp_tgt  = pc4 + imm * 32'd4;
    exp_pc   = exp_take ? exp_tgt : pc4;
    @(negedge clk);
    br_en = en; br_cond = c; pc_plus4 = pc4; imm_ext = imm;
    alu_result = diff; zero_flag = (diff == 32'd0);
    #1;
    check(cond_req(c, en), {31'd0, br_taken}, {31'd0, exp_take});
    check("R6", br_target, exp_tgt);
    @(posedge clk); #1;
    check(en ? "R7" : "R5", pc_q, exp_pc);
  endtask

  initial begin
    logic [31:0] as [7];
    logic [31:0] bs [7];
    logic [31:0] imms [5];
    as = '{32'd5, 32'd5, 32'd7, 32'hFFFF_FFFD, 32'd0, 32'h8000_0000, 32'h7FFF_FFFF};
    bs = '{32'd5, 32'd7, 32'd5, 32'd0, 32'd0, 32'd0, 32'd0};
    imms = '{32'd0, 32'd1, 32'hFFFF_FFF8, 32'h0000_7FFF, 32'hFFFF_8000};
    rst = 1'b1; br_en = 1'b0; br_cond = 2'b00; alu_result = '0;
    zero_flag = 1'b0; pc_plus4 = 32'h0000_1004; imm_ext = '0;
    repeat (2) @(posedge clk);
    #1 check("R8", pc_q, 32'd0);
    @(negedge clk) rst = 1'b0;
    for (int c = 0; c < 4; c++)
      for (int e = 0; e < 2; e++)
        for (int p = 0; p < 7; p++)
          for (int k = 0; k < 5; k++)
            step(as[p], (c >= 2) ? 32'd0 : bs[p], c[1:0], e[0],
                 32'h0040_0000 + 32'(p * 256 + k * 16), imms[k]);
    // backward offset of -8 words: 32 bytes below pc_plus4 (R6)
    step(32'd3, 32'd3, 2'b00, 1'b1, 32'h0000_0100, 32'hFFFF_FFF8);
    check("R6", pc_q, 32'h0000_00E0);
    // wrap below address zero (R6)
    step(32'd1, 32'd2, 2'b01, 1'b1, 32'h0000_0004, 32'hFFFF_FFF8);
    // reset wins over a taken branch (R8)
    @(negedge clk);
    rst = 1'b1; br_en = 1'b1; br_cond = 2'b00; zero_flag = 1'b1; alu_result = '0;
    pc_plus4 = 32'h0000_2000; imm_ext = 32'd4;
    @(posedge clk); #1;
    check("R8", pc_q, 32'd0);
    @(negedge clk) rst = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule